// File: doc/BRIEF.md
# Host Byte Port for a 12-bit Sample Store

This block lets an 8-bit microprocessor read and fill a memory of 12-bit samples through a single byte-wide window. The processor never supplies a word address. A counter inside the block holds the current word address. Each read or write strobe made while the board is selected moves that counter on by one word. A lane-select address bit from the host picks which part of the 12-bit word the byte bus carries: the lower eight bits, or the top four bits packed into the low nibble.

The host strobes are asynchronous. They pass through a two-stage synchroniser, and a falling edge on either strobe becomes a single-cycle access event. The event toggles an access flag. The XOR of that flag with the counter's least significant bit forms the increment pulse. The pulse ends by itself once the counter has stepped, so each access adds exactly one count. An active-low bypass input returns the flag and the counter to their start state.

Writes are merged into the word. The untouched lane of the addressed word is taken from the memory's read port and written back unchanged. Only the selected lane changes.

Top module: `smp_store_port`

## Requirements
- R1: A falling edge on `rd_n` or `wr_n` while `brd_sel_n` is low advances `mem_addr` by exactly one. Strobes made while `brd_sel_n` is high leave `mem_addr` unchanged and never assert `mem_we`.
- R2: When a strobe falls between two clock edges, `mem_addr` still holds its old value after the third following rising edge and holds the incremented value after the fourth. The internal increment pulse lasts one cycle for each isolated access.
- R3: The address counter is `ADDR_W` bits wide and wraps from its all-ones value to zero.
- R4: Holding `bypass_n` low for at least four clock cycles forces `mem_addr` to zero, and the following access moves it to one.
- R5: `hbus_oe` is high exactly while `brd_sel_n`, `mem_sel_n` and `rd_n` are all low, and `hbus_out` is zero whenever `hbus_oe` is low. With `lane_hi` = 0, `hbus_out` carries bits 7..0 of `mem_rdata`. With `lane_hi` = 1, it carries bits 11..8 in bits 3..0, and bits 7..4 are zero.
- R6: A write access with `brd_sel_n` and `mem_sel_n` both low asserts `mem_we` for exactly one cycle, on the third rising edge after `wr_n` falls, at the old address. With `lane_hi` = 0, `hbus_in[7:0]` replaces word bits 7..0. With `lane_hi` = 1, `hbus_in[3:0]` replaces word bits 11..8. The other lane keeps its stored value.
- R7: With `mem_sel_n` high, a strobe under board select still advances the address, but `mem_we` stays low and `hbus_oe` stays low.
- R8: After reset, `mem_addr` is zero and `hbus_oe` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brd_sel_n | input | 1 | Active-low board select |
| mem_sel_n | input | 1 | Active-low memory-access select |
| rd_n | input | 1 | Active-low host read strobe |
| wr_n | input | 1 | Active-low host write strobe |
| lane_hi | input | 1 | Lane select: 0 = bits 7..0, 1 = bits 11..8 |
| hbus_in | input | 8 | Host data toward storage |
| hbus_out | output | 8 | Storage data toward host |
| hbus_oe | output | 1 | Host bus drive enable |
| bypass_n | input | 1 | Active-low clear of access flag and address counter |
| mem_addr | output | ADDR_W | Word address to the sample memory |
| mem_rdata | input | 12 | Word read from the memory at `mem_addr` |
| mem_wdata | output | 12 | Merged word to write |
| mem_we | output | 1 | Single-cycle memory write enable |

## Verification
The bench builds the block with `ADDR_W` = 6, which gives a 64-word store. At that size, every word can be written and read back in both lanes, and a full pass of 64 accesses crosses the counter wrap. The bench also sets the strobe-to-address latency against exact clock edges. It checks the deselected cases, where the board or memory select is high, and the bypass clear, comparing each one with a shadow copy of the store kept in the bench.

// File: rtl/smp_store_pkg.sv
package smp_store_pkg;
  localparam int HOST_W = 8;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } lane_e;
endpackage

// File: rtl/smp_sync.sv
module smp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q;
  logic [STAGES-1:0][W-1:0] st_d;

  always_comb begin
    st_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      st_d[i] = st_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= {STAGES{RST_VAL}};
    end else begin
      st_q <= st_d;
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/smp_addr_ctr.sv
module smp_addr_ctr #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              evt,
  output logic [ADDR_W-1:0] addr,
  output logic              inc
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  logic              flag_q, flag_d, flag_en;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  // step pulse: flag and counter LSB disagree until the counter catches up
  assign inc = flag_q ^ addr_q[0];

  always_comb begin
    flag_en = clr | evt;
    flag_d  = clr ? 1'b0 : ~flag_q;
    addr_en = clr | inc;
    addr_d  = clr ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  // R2: an isolated access yields a one-cycle step
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !evt && !clr) |=> !inc);
  // R1: no step, no movement
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(addr_q));
  // R1: a step moves by one
  a_r1_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && addr_q != ADDR_MAX) |=> addr_q == $past(addr_q) + 1'b1);
  // R3: wrap to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && addr_q == ADDR_MAX) |=> addr_q == '0);
  // R4: clear returns to start state
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr_q == '0 && !flag_q && !inc));
endmodule

// File: rtl/smp_lane_path.sv
module smp_lane_path
  import smp_store_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              lane_hi,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic [WORD_W-1:0] word_rdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic [WORD_W-1:0] word_wdata
);
  localparam int HI_W = WORD_W - HOST_W;

  lane_e sel;
  assign sel = lane_e'(lane_hi);

  always_comb begin
    if (sel == LANE_HI) begin
      host_rdata = {{(HOST_W-HI_W){1'b0}}, word_rdata[WORD_W-1:HOST_W]};
      word_wdata = {host_wdata[HI_W-1:0], word_rdata[HOST_W-1:0]};
    end else begin
      host_rdata = word_rdata[HOST_W-1:0];
      word_wdata = {word_rdata[WORD_W-1:HOST_W], host_wdata};
    end
  end
endmodule

// File: rtl/smp_store_port.sv
module smp_store_port
  import smp_store_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brd_sel_n,
  input  logic              mem_sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              lane_hi,
  input  logic [7:0]        hbus_in,
  output logic [7:0]        hbus_out,
  output logic              hbus_oe,
  input  logic              bypass_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we
);
  localparam int HI_W = WORD_W - HOST_W;
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, syn_q;
  logic bypass_s, brd_s, rd_s, wr_s;
  logic rd_p, wr_p;
  logic rd_fall, wr_fall, acc_evt, wr_evt;
  logic step;
  logic [HOST_W-1:0] lane_rdata;

  assign raw_in = {bypass_n, brd_sel_n, rd_n, wr_n};

  smp_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (syn_q)
  );

  assign {bypass_s, brd_s, rd_s, wr_s} = syn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p <= 1'b1;
      wr_p <= 1'b1;
    end else begin
      rd_p <= rd_s;
      wr_p <= wr_s;
    end
  end

  always_comb begin
    rd_fall = rd_p & ~rd_s;
    wr_fall = wr_p & ~wr_s;
    acc_evt = (rd_fall | wr_fall) & ~brd_s;
    wr_evt  = wr_fall & ~brd_s & ~mem_sel_n;
  end

  smp_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~bypass_s),
    .evt   (acc_evt),
    .addr  (mem_addr),
    .inc   (step)
  );

  smp_lane_path #(.WORD_W(WORD_W)) u_lane (
    .lane_hi    (lane_hi),
    .host_wdata (hbus_in),
    .word_rdata (mem_rdata),
    .host_rdata (lane_rdata),
    .word_wdata (mem_wdata)
  );

  assign hbus_oe  = ~brd_sel_n & ~mem_sel_n & ~rd_n;
  assign hbus_out = hbus_oe ? lane_rdata : '0;
  assign mem_we   = wr_evt;

  // R2: strobe edge detector gives one-cycle events
  a_r2_evt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> !acc_evt);
  // R6: write enable is a single cycle
  a_r6_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R7: no write without memory select
  a_r7_no_we_unsel: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_n |-> !mem_we);
  // R6: upper-lane write keeps the low lane
  a_r6_keep_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && lane_hi) |-> mem_wdata[HOST_W-1:0] == mem_rdata[HOST_W-1:0]);
  // R6: lower-lane write keeps the upper lane
  a_r6_keep_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !lane_hi) |-> mem_wdata[WORD_W-1:HOST_W] == mem_rdata[WORD_W-1:HOST_W]);
  // R5: upper lane read pads the high bits with zero
  a_r5_hi_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (hbus_oe && lane_hi) |-> hbus_out[HOST_W-1:HI_W] == '0);
  // R5: quiet bus when not driving
  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hbus_oe |-> hbus_out == '0);
endmodule

// File: tb/smp_store_port_tb.sv
module smp_store_port_tb_top;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk, rst_n;
  logic brd_sel_n, mem_sel_n, rd_n, wr_n, lane_hi, bypass_n;
  logic [7:0] hbus_in, hbus_out;
  logic hbus_oe;
  logic [ADDR_W-1:0] mem_addr;
  logic [11:0] mem_rdata, mem_wdata;
  logic mem_we;

  logic [11:0] store [DEPTH];
  logic [11:0] shadow [DEPTH];
  int n_cmp, n_bad, we_cnt, ea;
  bit done;

  smp_store_port #(.ADDR_W(ADDR_W), .WORD_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .brd_sel_n(brd_sel_n), .mem_sel_n(mem_sel_n),
    .rd_n(rd_n), .wr_n(wr_n), .lane_hi(lane_hi), .hbus_in(hbus_in),
    .hbus_out(hbus_out), .hbus_oe(hbus_oe), .bypass_n(bypass_n),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .mem_we(mem_we)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign mem_rdata = store[mem_addr];
  always @(posedge clk) begin
    if (mem_we) begin
      store[mem_addr] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit is_rd, input bit brd, input bit msel, input bit hi,
                        input logic [7:0] d, output logic [7:0] got, output logic oe_got);
    @(negedge clk);
    brd_sel_n = !brd; mem_sel_n = !msel; lane_hi = hi; hbus_in = d;
    @(negedge clk);
    if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
    #5;
    got = hbus_out; oe_got = hbus_oe;
    repeat (5) @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    brd_sel_n = 1'b1; mem_sel_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic op(input bit is_rd, input bit brd, input bit msel, input bit hi,
                    input logic [7:0] d);
    logic [7:0] got;
    logic oe_got;
    int we0, a0;
    we0 = we_cnt; a0 = ea;
    access(is_rd, brd, msel, hi, d, got, oe_got);
    if (is_rd) begin
      chk("R5/R7 oe during read", oe_got, brd & msel);
      if (brd && msel)
        chk("R5 read lane data", got, hi ? {4'h0, shadow[a0][11:8]} : {24'h0, shadow[a0][7:0]});
      else
        chk("R5 quiet bus", got, 0);
    end else begin
      chk("R6/R7 write pulse count", we_cnt - we0, (brd && msel) ? 1 : 0);
      if (brd && msel) begin
        if (hi) shadow[a0][11:8] = d[3:0];
        else    shadow[a0][7:0]  = d;
      end
    end
    if (brd) ea = (ea + 1) % DEPTH;
    chk("R1 address after access", mem_addr, ea);
  endtask

  task automatic cmp_store(input string req);
    for (int i = 0; i < DEPTH; i++) chk(req, store[i], shadow[i]);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; we_cnt = 0; ea = 0; done = 0;
    for (int i = 0; i < DEPTH; i++) begin
      store[i]  = 12'((i * 37 + 5));
      shadow[i] = 12'((i * 37 + 5));
    end
    rst_n = 1'b0; brd_sel_n = 1'b1; mem_sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    lane_hi = 1'b0; bypass_n = 1'b1; hbus_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset address", mem_addr, 0);
    chk("R8 reset oe", hbus_oe, 0);
    chk("R8 reset we", mem_we, 0);

    // R6: lower lane fill across every word; R3 wrap at the end
    for (int i = 0; i < DEPTH; i++) op(1'b0, 1'b1, 1'b1, 1'b0, 8'(i * 7 + 3));
    chk("R3 wrap to zero", mem_addr, 0);
    cmp_store("R6 low lane store");
    // R6: upper lane fill with junk in the high nibble
    for (int i = 0; i < DEPTH; i++) op(1'b0, 1'b1, 1'b1, 1'b1, 8'((i * 29) ^ 8'hC0));
    cmp_store("R6 merged store");
    // R5: read back both lanes
    for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);

    // R1: board not selected
    for (int i = 0; i < 4; i++) op(i[0], 1'b0, 1'b1, i[1], 8'h5A);
    // R7: memory not selected
    for (int i = 0; i < 4; i++) op(i[0], 1'b1, 1'b0, i[1], 8'hA5);
    cmp_store("R7 store untouched");

    // R2: edge-exact latency
    begin
      int a0;
      @(negedge clk);
      brd_sel_n = 1'b0; mem_sel_n = 1'b1;
      @(negedge clk);
      a0 = ea;
      wr_n = 1'b0;
      repeat (3) @(posedge clk);
      #5 chk("R2 address after third edge", mem_addr, a0);
      @(posedge clk);
      #5 chk("R2 address after fourth edge", mem_addr, (a0 + 1) % DEPTH);
      @(negedge clk);
      wr_n = 1'b1;
      repeat (3) @(negedge clk);
      brd_sel_n = 1'b1;
      ea = (a0 + 1) % DEPTH;
      @(negedge clk);
    end

    // R4: bypass clear
    for (int i = 0; i < 3; i++) op(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    bypass_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 address cleared", mem_addr, 0);
    bypass_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 address stays zero", mem_addr, 0);
    ea = 0;
    op(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R4 first access after clear", mem_addr, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule